// File: doc/BRIEF.md
# Two-Level DFA Multi-Pattern Matcher

This block scans two independent byte streams for a dictionary of patterns by stepping a fully resolved automaton of the Aho-Corasick kind. Every byte costs exactly one transition lookup, keyed by the current state and the byte, and that lookup yields the next state. The complete transition table is too large for on-chip storage, so it lives behind a long-latency external memory port. Only the rows of a small set of frequently visited ("hot") states are kept in an on-chip table. A lookup from a hot state is answered locally and never reaches the external port.

Two matching cores share the on-chip table through a round-robin arbiter. Each core takes one byte at a time through a valid/ready handshake. A core lowers ready while its lookup is in flight, and a cold lookup can take many cycles. When the state reached carries a match flag, the core pulses a match strobe together with the state ID and the position of the byte within its stream. Software builds the automaton and picks the hot states. It fills the on-chip table through a load port while both cores are idle.

Top module: `dfa_match_engine`

## Requirements
- R1: For each accepted byte, a core moves from state S to next(S, byte), and the following byte is looked up from that new state.
- R2: States whose 16-bit ID is below 2**HOT_BITS are hot. Their lookups read the on-chip table and never raise mem_req_valid.
- R3: A lookup from a cold state raises mem_req_valid for exactly one cycle, with address {state[15:0], byte[7:0]}: the state in bits 23:8 and the byte in bits 7:0. in_ready stays low until mem_rsp_valid returns the next state and its match flag. Each core has at most one request outstanding.
- R4: When the next state's match flag is 1, match_valid pulses high for one cycle, with match_state equal to the new state and match_offset equal to the byte's position in the stream.
- R5: A byte presented with in_sos high is looked up from state 0 and has offset 0. Offsets count up by one per byte until the next in_sos.
- R6: After reset, every core is in state 0 with offset 0 and in_ready high, with no memory request and no match strobe.
- R7: When both cores request the shared table in the same cycle, exactly one is granted, with priority alternating round-robin. The other core is served in the next cycle, and its result still equals the true next state.
- R8: A load write places {load_match, load_state} into the table entry at index {state low bits, byte} only when both cores are idle (in_ready high). A load attempted while either core is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 2 | Byte valid, one bit per core |
| in_ready | output | 2 | Core can accept a byte |
| in_data | input | 16 | Byte per core, core k in bits 8k+7:8k |
| in_sos | input | 2 | Byte starts a new stream |
| mem_req_valid | output | 2 | External lookup request pulse per core |
| mem_req_addr | output | 48 | Request address {state, byte} per core, 24 bits each |
| mem_rsp_valid | input | 2 | External lookup response per core |
| mem_rsp_state | input | 32 | Returned next state, 16 bits per core |
| mem_rsp_match | input | 2 | Returned match flag per core |
| match_valid | output | 2 | Match strobe per core |
| match_state | output | 32 | Matched state ID, 16 bits per core |
| match_offset | output | 32 | Byte offset in stream, 16 bits per core |
| load_en | input | 1 | Table write strobe |
| load_addr | input | HOT_BITS+8 | Table index {hot state, byte} |
| load_state | input | 16 | Next state written to the entry |
| load_match | input | 1 | Match flag written to the entry |

## Verification
A corrupted current state in a core does not stay hidden for long. The next lookup goes to the wrong table row, which shows as a missing, extra or wrong match report, or as an external request whose state field disagrees with the reference automaton. That request appears on the very next byte that leaves the hot region. A wrong offset register shows on the next match strobe. A broken arbiter or a stray load write corrupts the next state itself, and that error then spreads through every later report in that stream.

// File: rtl/dfa_pkg.sv
// Shared widths and the on-chip table entry layout for the DFA matcher.
// Assumes 16-bit state IDs and 8-bit input symbols.
package dfa_pkg;
    localparam int ST_W   = 16;
    localparam int CH_W   = 8;
    localparam int ADDR_W = ST_W + CH_W;

    typedef struct packed {
        logic            hit;
        logic [ST_W-1:0] nstate;
    } hot_entry_t;
endpackage

// File: rtl/dfa_hot_table.sv
// On-chip transition rows for the hot states: one write port for loading,
// one registered read port shared by the cores through the arbiter.
// Assumes read and write never occur in the same cycle (load only when idle).
module dfa_hot_table
    import dfa_pkg::*;
#(
    parameter int HOT_BITS = 3
) (
    input  logic                   clk,
    input  logic                   we,
    input  logic [HOT_BITS+CH_W-1:0] waddr,
    input  hot_entry_t             wdata,
    input  logic                   re,
    input  logic [HOT_BITS+CH_W-1:0] raddr,
    output hot_entry_t             rdata
);
    localparam int DEPTH = 1 << (HOT_BITS + CH_W);

    hot_entry_t mem [DEPTH];

    // Write on load, registered read on a granted lookup.
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
        if (re)
            rdata <= mem[raddr];
    end
endmodule

// File: rtl/dfa_rr_arb.sv
// Two-way round-robin arbiter for the shared table read port.
// Assumes a requester holds its request until it is granted.
module dfa_rr_arb (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req,
    output logic [1:0] gnt
);
    logic prio_one;   // 1: requester 1 wins a tie

    // Grant selection: a tie goes to the side holding priority.
    always_comb begin
        gnt = 2'b00;
        if (req == 2'b11)
            gnt = prio_one ? 2'b10 : 2'b01;
        else
            gnt = req;
    end

    // Priority moves to the other side after each grant.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prio_one <= 1'b0;
        else if (gnt[0])
            prio_one <= 1'b1;
        else if (gnt[1])
            prio_one <= 1'b0;
    end

    p_gnt_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    p_gnt_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == 2'b00);
    p_rr_zero_then_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req == 2'b11 && gnt[0]) |=> (!req[1] || gnt[1]));
    p_rr_one_then_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req == 2'b11 && gnt[1]) |=> (!req[0] || gnt[0]));
endmodule

// File: rtl/dfa_core.sv
// One matching core: accepts a byte, looks up next(state, byte) either in the
// shared hot table (via arbiter) or through the external memory port, then
// updates its state and reports matches with the byte offset.
// Assumes the external memory answers each request exactly once.
module dfa_core
    import dfa_pkg::*;
#(
    parameter int HOT_BITS = 3,
    parameter int OFF_W    = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [CH_W-1:0]          in_data,
    input  logic                     in_sos,
    output logic                     in_ready,
    output logic                     hot_req,
    output logic [HOT_BITS+CH_W-1:0] hot_addr,
    input  logic                     hot_gnt,
    input  hot_entry_t               hot_rdata,
    output logic                     mem_req_valid,
    output logic [ADDR_W-1:0]        mem_req_addr,
    input  logic                     mem_rsp_valid,
    input  logic [ST_W-1:0]          mem_rsp_state,
    input  logic                     mem_rsp_match,
    output logic                     match_valid,
    output logic [ST_W-1:0]          match_state,
    output logic [OFF_W-1:0]         match_offset
);
    localparam logic [ST_W-1:0] HOT_LIM = ST_W'(1 << HOT_BITS);

    typedef enum logic [2:0] {S_IDLE, S_HREQ, S_HWAIT, S_CREQ, S_CWAIT} step_t;

    step_t            st;
    logic [ST_W-1:0]  cur;
    logic [ST_W-1:0]  lk;
    logic [CH_W-1:0]  ch;
    logic [OFF_W-1:0] off_q;
    logic [OFF_W-1:0] byte_off;

    logic             fire;
    logic [ST_W-1:0]  start_state;
    logic [OFF_W-1:0] start_off;
    logic             done;
    logic [ST_W-1:0]  done_state;
    logic             done_hit;

    assign in_ready      = (st == S_IDLE);
    assign fire          = in_valid && in_ready;
    assign start_state   = in_sos ? '0 : cur;
    assign start_off     = in_sos ? '0 : off_q;
    assign hot_req       = (st == S_HREQ);
    assign hot_addr      = {lk[HOT_BITS-1:0], ch};
    assign mem_req_valid = (st == S_CREQ);
    assign mem_req_addr  = {lk, ch};

    // Result selection: on-chip data one cycle after grant, or external response.
    always_comb begin
        done       = 1'b0;
        done_state = hot_rdata.nstate;
        done_hit   = hot_rdata.hit;
        if (st == S_HWAIT) begin
            done = 1'b1;
        end else if (st == S_CWAIT && mem_rsp_valid) begin
            done       = 1'b1;
            done_state = mem_rsp_state;
            done_hit   = mem_rsp_match;
        end
    end

    // Lookup sequencing, state update and match reporting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st           <= S_IDLE;
            cur          <= '0;
            lk           <= '0;
            ch           <= '0;
            off_q        <= '0;
            byte_off     <= '0;
            match_valid  <= 1'b0;
            match_state  <= '0;
            match_offset <= '0;
        end else begin
            match_valid <= 1'b0;
            case (st)
                S_IDLE: if (fire) begin
                    lk       <= start_state;
                    ch       <= in_data;
                    byte_off <= start_off;
                    off_q    <= start_off + 1'b1;
                    st       <= (start_state < HOT_LIM) ? S_HREQ : S_CREQ;
                end
                S_HREQ: if (hot_gnt) st <= S_HWAIT;
                S_CREQ: st <= S_CWAIT;
                default: ;
            endcase
            if (done) begin
                cur          <= done_state;
                match_valid  <= done_hit;
                match_state  <= done_state;
                match_offset <= byte_off;
                st           <= S_IDLE;
            end
        end
    end

    p_match_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        match_valid |=> !match_valid);
    p_cold_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[ADDR_W-1:CH_W] >= HOT_LIM));
    p_single_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);
    p_stall_on_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !in_ready);
endmodule

// File: rtl/dfa_match_engine.sv
// Top: two matching cores sharing one on-chip hot-state table through a
// round-robin arbiter, each with its own external memory request port.
// Assumes the table is loaded only while both cores are idle; other loads drop.
module dfa_match_engine
    import dfa_pkg::*;
#(
    parameter int HOT_BITS = 3,
    parameter int OFF_W    = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               in_valid,
    output logic [1:0]               in_ready,
    input  logic [2*CH_W-1:0]        in_data,
    input  logic [1:0]               in_sos,
    output logic [1:0]               mem_req_valid,
    output logic [2*ADDR_W-1:0]      mem_req_addr,
    input  logic [1:0]               mem_rsp_valid,
    input  logic [2*ST_W-1:0]        mem_rsp_state,
    input  logic [1:0]               mem_rsp_match,
    output logic [1:0]               match_valid,
    output logic [2*ST_W-1:0]        match_state,
    output logic [2*OFF_W-1:0]       match_offset,
    input  logic                     load_en,
    input  logic [HOT_BITS+CH_W-1:0] load_addr,
    input  logic [ST_W-1:0]          load_state,
    input  logic                     load_match
);
    localparam int NCORE = 2;
    localparam int TA_W  = HOT_BITS + CH_W;

    logic [NCORE-1:0] hot_req;
    logic [NCORE-1:0] hot_gnt;
    logic [TA_W-1:0]  hot_addr [NCORE];
    hot_entry_t       rdata;
    logic             tbl_we;
    logic [TA_W-1:0]  tbl_raddr;

    assign tbl_we    = load_en && (&in_ready);
    assign tbl_raddr = hot_gnt[1] ? hot_addr[1] : hot_addr[0];

    dfa_rr_arb u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (hot_req),
        .gnt   (hot_gnt)
    );

    dfa_hot_table #(.HOT_BITS(HOT_BITS)) u_table (
        .clk   (clk),
        .we    (tbl_we),
        .waddr (load_addr),
        .wdata ('{hit: load_match, nstate: load_state}),
        .re    (|hot_gnt),
        .raddr (tbl_raddr),
        .rdata (rdata)
    );

    for (genvar k = 0; k < NCORE; k++) begin : g_core
        dfa_core #(.HOT_BITS(HOT_BITS), .OFF_W(OFF_W)) u_core (
            .clk           (clk),
            .rst_n         (rst_n),
            .in_valid      (in_valid[k]),
            .in_data       (in_data[k*CH_W +: CH_W]),
            .in_sos        (in_sos[k]),
            .in_ready      (in_ready[k]),
            .hot_req       (hot_req[k]),
            .hot_addr      (hot_addr[k]),
            .hot_gnt       (hot_gnt[k]),
            .hot_rdata     (rdata),
            .mem_req_valid (mem_req_valid[k]),
            .mem_req_addr  (mem_req_addr[k*ADDR_W +: ADDR_W]),
            .mem_rsp_valid (mem_rsp_valid[k]),
            .mem_rsp_state (mem_rsp_state[k*ST_W +: ST_W]),
            .mem_rsp_match (mem_rsp_match[k]),
            .match_valid   (match_valid[k]),
            .match_state   (match_state[k*ST_W +: ST_W]),
            .match_offset  (match_offset[k*OFF_W +: OFF_W])
        );
    end
endmodule

// File: tb/dfa_match_engine_test.sv
// Scoreboard bench: drivers step a reference automaton and queue expected
// matches; a monitor pops and compares as match strobes appear.
module dfa_match_engine_test;
    localparam int HB   = 3;
    localparam int HOTN = 1 << HB;
    localparam int NST  = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  in_valid = '0;
    logic [1:0]  in_ready;
    logic [15:0] in_data = '0;
    logic [1:0]  in_sos = '0;
    logic [1:0]  mem_req_valid;
    logic [47:0] mem_req_addr;
    logic [1:0]  mem_rsp_valid = '0;
    logic [31:0] mem_rsp_state = '0;
    logic [1:0]  mem_rsp_match = '0;
    logic [1:0]  match_valid;
    logic [31:0] match_state;
    logic [31:0] match_offset;
    logic        load_en = 1'b0;
    logic [HB+7:0] load_addr = '0;
    logic [15:0] load_state = '0;
    logic        load_match = 1'b0;

    int total = 0;
    int bad = 0;
    int seen [2] = '{0, 0};
    logic [15:0] cur [2] = '{16'd0, 16'd0};
    logic [15:0] offc [2] = '{16'd0, 16'd0};
    logic [31:0] q0 [$];
    logic [31:0] q1 [$];

    always #2.5 clk = ~clk;

    dfa_match_engine #(.HOT_BITS(HB), .OFF_W(16)) uut (.*);

    function automatic logic [15:0] nxt(input logic [15:0] s, input logic [7:0] c);
        return 16'((32'(s) * 7 + 32'(c)) % NST);
    endfunction
    function automatic logic hitf(input logic [15:0] s);
        return (s == 16'd7) || (s == 16'd10);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Driver: present one byte, update the model, queue any expected match (R1, R4, R5).
    task automatic put(input int k, input logic [7:0] c, input bit sos);
        logic [15:0] s, n, o;
        s = sos ? 16'd0 : cur[k];
        o = sos ? 16'd0 : offc[k];
        n = nxt(s, c);
        cur[k] = n;
        offc[k] = o + 16'd1;
        if (hitf(n)) begin
            if (k == 0) q0.push_back({n, o}); else q1.push_back({n, o});
        end
        @(negedge clk);
        in_valid[k] = 1'b1;
        in_data[k*8 +: 8] = c;
        in_sos[k] = sos;
        while (!in_ready[k]) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid[k] = 1'b0;
        in_sos[k] = 1'b0;
    endtask

    task automatic stream(input int k, input int len, input int seed);
        logic [31:0] r;
        r = 32'(seed);
        for (int i = 0; i < len; i++) begin
            r = r * 32'd1103515245 + 32'd12345;
            put(k, r[23:16], (i == 0) || (i == 97));
        end
    endtask

    // Monitor: compare each match strobe with the queued expectation (R4).
    initial begin
        forever begin
            @(negedge clk);
            for (int k = 0; k < 2; k++) begin
                if (rst_n && match_valid[k]) begin
                    logic [31:0] got, exp;
                    got = {match_state[k*16 +: 16], match_offset[k*16 +: 16]};
                    seen[k]++;
                    if ((k == 0 && q0.size() == 0) || (k == 1 && q1.size() == 0)) begin
                        chk(0, "R4", "unexpected match", got, 0);
                    end else begin
                        exp = (k == 0) ? q0.pop_front() : q1.pop_front();
                        chk(got == exp, "R4", "match {state,offset}", got, exp);
                    end
                end
            end
        end
    end

    // External memory model with varying latency; checks request rules (R2, R3).
    initial begin
        int cnt [2];
        int lat_seq;
        logic [23:0] adr [2];
        cnt = '{0, 0};
        lat_seq = 0;
        forever begin
            @(negedge clk);
            for (int k = 0; k < 2; k++) begin
                mem_rsp_valid[k] = 1'b0;
                if (cnt[k] > 0) begin
                    chk(in_ready[k] == 1'b0, "R3", "ready low while waiting", in_ready[k], 0);
                    cnt[k]--;
                    if (cnt[k] == 0) begin
                        mem_rsp_valid[k] = 1'b1;
                        mem_rsp_state[k*16 +: 16] = nxt(adr[k][23:8], adr[k][7:0]);
                        mem_rsp_match[k] = hitf(nxt(adr[k][23:8], adr[k][7:0]));
                    end
                end
                if (rst_n && mem_req_valid[k]) begin
                    adr[k] = mem_req_addr[k*24 +: 24];
                    chk(adr[k][23:8] >= HOTN, "R2", "request only for cold state", adr[k][23:8], HOTN);
                    chk(cnt[k] == 0, "R3", "single outstanding request", cnt[k], 0);
                    lat_seq++;
                    cnt[k] = 2 + (lat_seq % 5);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "R1", "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int s0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6: reset state at the ports.
        chk(in_ready == 2'b11, "R6", "ready after reset", in_ready, 3);
        chk(mem_req_valid == 2'b00, "R6", "no request after reset", mem_req_valid, 0);
        chk(match_valid == 2'b00, "R6", "no match after reset", match_valid, 0);

        // R8: fill hot rows while idle.
        for (int s = 0; s < HOTN; s++) begin
            for (int c = 0; c < 256; c++) begin
                @(negedge clk);
                load_en = 1'b1;
                load_addr = {3'(s), 8'(c)};
                load_state = nxt(16'(s), 8'(c));
                load_match = hitf(nxt(16'(s), 8'(c)));
            end
        end
        @(negedge clk);
        load_en = 1'b0;

        // R6/R1: first byte with no start marker walks from state 0 (0 -> 7 match).
        put(1, 8'd7, 1'b0);
        put(1, 8'd4, 1'b0);
        repeat (10) @(negedge clk);
        chk(q1.size() == 0, "R6", "reset-state walk matches consumed", q1.size(), 0);

        // R7/R1/R5: both cores run concurrently and contend for the table.
        fork
            stream(0, 300, 11);
            stream(1, 300, 77);
        join
        repeat (20) @(negedge clk);
        chk(q0.size() == 0, "R7", "core0 matches all reported", q0.size(), 0);
        chk(q1.size() == 0, "R7", "core1 matches all reported", q1.size(), 0);

        // R8: a load while a core is busy is ignored.
        put(0, 8'd9, 1'b1);   // state 9 (cold)
        fork
            put(0, 8'd1, 1'b0);
            begin
                @(negedge clk);
                while (!mem_req_valid[0]) @(negedge clk);
                load_en = 1'b1;
                load_addr = {3'd0, 8'h51};
                load_state = 16'd7;
                load_match = 1'b1;
                @(negedge clk);
                load_en = 1'b0;
            end
        join
        repeat (12) @(negedge clk);
        s0 = seen[0];
        put(0, 8'h51, 1'b1);  // true entry: state 9, no match
        repeat (8) @(negedge clk);
        chk(seen[0] == s0, "R8", "busy load ignored (no match)", seen[0], s0);
        put(0, 8'd4, 1'b0);   // from 9 -> 7, match at offset 1
        repeat (12) @(negedge clk);
        chk(seen[0] == s0 + 1, "R8", "state continues from real entry", seen[0], s0 + 1);
        chk(q0.size() == 0, "R5", "start marker reset offset queue drained", q0.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule